// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small processor, built as a microprogram engine instead of a hard-wired state machine. A control address register selects a word in a read-only control store that is built into the module. The selected word is copied into a control buffer register. The buffered word then drives the processor's control lines through four small encoded fields. It also chooses which word runs next.

Each microinstruction takes two clocks. In the first clock (fetch) the addressed word is loaded into the buffer. In the second clock (execute) the control lines are driven and the address register is loaded with the next microaddress. The next microaddress is one of four choices: the current address plus one; an unconditional jump to the word's single address field; a jump to that field only when a selected ALU flag is set; or a dispatch to a routine whose address is derived from the opcode in the instruction register. The resident microprogram holds a fetch routine at address 0 and one short routine for each of several opcodes. Each routine returns to the fetch routine.

Top module: `ucu_sequencer`

## Requirements
- R1: While rst_ni is low, and immediately after it falls (asynchronously), uaddr_o is 0 and every control output is 0. After rst_ni is released, the first microinstruction executed is the one at address 0.
- R2: Every microinstruction takes exactly two clocks: a fetch clock, during which all control outputs are 0, and an execute clock, during which its control fields are driven. uaddr_o holds the address of that microinstruction across both clocks and changes only when execute ends.
- R3: Each control group decodes its field code v: v = 0 drives no line in the group, and v > 0 drives only bit v-1 of the group's output. The src, dst and alu groups each use 3-bit codes (7 lines), and the mem group uses a 2-bit code (3 lines). Different groups may drive lines in the same clock.
- R4: Next-address code 00 loads the address register with the current address plus one.
- R5: Next-address code 01 loads the address field of the word, whatever the flags are.
- R6: Next-address code 10 loads the address field if flags_i[s] = 1, where s is the 2-bit flag select (0 zero, 1 negative, 2 carry, 3 overflow); otherwise it loads address plus one. Flags that are not selected have no effect.
- R7: Next-address code 11 loads opcode_i × 4. The opcode is sampled only at the end of the execute clock of that word, so its value at any other time has no effect.
- R8: Incrementing from address 63 wraps to address 0.
- R9: The resident microprogram (address: src,dst,alu,mem codes; next) is: 0: 1,1,0,1; +1. 1: 2,2,1,0; +1. 2: none; dispatch. 4: 3,3,2,0; +1. 5: alu 3; if zero go to 7. 6: src 4, dst 4; go to 0. 7: dst 5, mem 2; go to 0. 8: alu 4; +1. 9: src 5; if carry go to 0. 10: dst 6; go to 0. 12: alu 6; if negative go to 14. 13: src 6; if overflow go to 0. 14: dst 7, mem 3; go to 0. 60–62: alu 5; +1. 63: alu 7; +1. Every other word: no controls; go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 4 | Opcode held in the instruction register |
| flags_i | input | 4 | ALU flags: bit 0 zero, bit 1 negative, bit 2 carry, bit 3 overflow |
| src_o | output | 7 | Decoded source-select control lines |
| dst_o | output | 7 | Decoded destination-select control lines |
| alu_o | output | 7 | Decoded ALU-operation control lines |
| mem_o | output | 3 | Decoded memory control lines |
| uaddr_o | output | 6 | Current control address |

## Verification
A microinstruction's controls appear one clock after its address is placed in the register, once the fetch edge has loaded the buffer. The next address is taken at the edge that ends the execute clock, and it uses the flags and opcode present just before that edge. The bench therefore drives flags and opcode before a step begins. It lets one edge pass and checks the address and the controls at the falling edge that follows. It then lets the second edge pass and checks, at the next falling edge, that all controls are low. Each routine's exit is confirmed by the next step, whose address check expects 0. The asynchronous reset check is sampled a short delay after rst_ni falls, with no clock edge in between.

// File: rtl/ucu_pkg.sv
package ucu_pkg;

  localparam int unsigned UADDR_W   = 6;
  localparam int unsigned OPC_W     = 4;
  localparam int unsigned GRP_W     = 3;
  localparam int unsigned MEM_W     = 2;
  localparam int unsigned FSEL_W    = 2;
  localparam int unsigned FLAG_N    = 1 << FSEL_W;
  localparam int unsigned MAP_SHIFT = 2;
  localparam int unsigned DEPTH     = 1 << UADDR_W;

  typedef enum logic [1:0] {
    NA_INC = 2'b00,
    NA_JMP = 2'b01,
    NA_JCC = 2'b10,
    NA_MAP = 2'b11
  } na_e;

  typedef enum logic [FSEL_W-1:0] {
    FL_ZERO  = 2'd0,
    FL_NEG   = 2'd1,
    FL_CARRY = 2'd2,
    FL_OVF   = 2'd3
  } flag_e;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_EXEC  = 1'b1
  } ph_e;

  typedef struct packed {
    na_e                na;
    flag_e              fsel;
    logic [UADDR_W-1:0] target;
    logic [GRP_W-1:0]   src;
    logic [GRP_W-1:0]   dst;
    logic [GRP_W-1:0]   alu;
    logic [MEM_W-1:0]   mem;
  } uword_t;

  function automatic uword_t mk_word(na_e na, flag_e fs, int unsigned tgt,
                                     int unsigned s, int unsigned d,
                                     int unsigned a, int unsigned m);
    uword_t w;
    w.na     = na;
    w.fsel   = fs;
    w.target = UADDR_W'(tgt);
    w.src    = GRP_W'(s);
    w.dst    = GRP_W'(d);
    w.alu    = GRP_W'(a);
    w.mem    = MEM_W'(m);
    return w;
  endfunction

  // resident microprogram; unlisted words return to fetch with no controls
  function automatic uword_t ucode_at(int unsigned addr);
    case (addr)
      0:       return mk_word(NA_INC, FL_ZERO,  0, 1, 1, 0, 1);
      1:       return mk_word(NA_INC, FL_ZERO,  0, 2, 2, 1, 0);
      2:       return mk_word(NA_MAP, FL_ZERO,  0, 0, 0, 0, 0);
      4:       return mk_word(NA_INC, FL_ZERO,  0, 3, 3, 2, 0);
      5:       return mk_word(NA_JCC, FL_ZERO,  7, 0, 0, 3, 0);
      6:       return mk_word(NA_JMP, FL_ZERO,  0, 4, 4, 0, 0);
      7:       return mk_word(NA_JMP, FL_ZERO,  0, 0, 5, 0, 2);
      8:       return mk_word(NA_INC, FL_ZERO,  0, 0, 0, 4, 0);
      9:       return mk_word(NA_JCC, FL_CARRY, 0, 5, 0, 0, 0);
      10:      return mk_word(NA_JMP, FL_ZERO,  0, 0, 6, 0, 0);
      12:      return mk_word(NA_JCC, FL_NEG,  14, 0, 0, 6, 0);
      13:      return mk_word(NA_JCC, FL_OVF,   0, 6, 0, 0, 0);
      14:      return mk_word(NA_JMP, FL_ZERO,  0, 0, 7, 0, 3);
      60, 61,
      62:      return mk_word(NA_INC, FL_ZERO,  0, 0, 0, 5, 0);
      63:      return mk_word(NA_INC, FL_ZERO,  0, 0, 0, 7, 0);
      default: return mk_word(NA_JMP, FL_ZERO,  0, 0, 0, 0, 0);
    endcase
  endfunction

endpackage

// File: rtl/ucu_store.sv
module ucu_store
  import ucu_pkg::*;
#(
  parameter int unsigned AW    = UADDR_W,
  localparam int unsigned WORDS = 1 << AW
) (
  input  logic [AW-1:0] addr_i,
  output uword_t        word_o
);

  uword_t rom [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    assign rom[i] = ucode_at(i);
  end

  assign word_o = rom[addr_i];

endmodule

// File: rtl/ucu_next_addr.sv
module ucu_next_addr
  import ucu_pkg::*;
#(
  parameter int unsigned AW    = UADDR_W,
  parameter int unsigned OW    = OPC_W,
  parameter int unsigned SHIFT = MAP_SHIFT
) (
  input  logic [AW-1:0]     car_i,
  input  na_e               na_i,
  input  flag_e             fsel_i,
  input  logic [AW-1:0]     target_i,
  input  logic [FLAG_N-1:0] flags_i,
  input  logic [OW-1:0]     opcode_i,
  output logic [AW-1:0]     nxt_o
);

  logic [AW-1:0] inc_addr;
  logic [AW-1:0] map_addr;
  logic          cond_hit;

  assign inc_addr = car_i + AW'(1);  // wraps at the top of the store
  assign map_addr = AW'({opcode_i, {SHIFT{1'b0}}});
  assign cond_hit = flags_i[fsel_i];

  always_comb begin
    unique case (na_i)
      NA_INC:  nxt_o = inc_addr;
      NA_JMP:  nxt_o = target_i;
      NA_JCC:  nxt_o = cond_hit ? target_i : inc_addr;
      NA_MAP:  nxt_o = map_addr;
      default: nxt_o = inc_addr;
    endcase
  end

endmodule

// File: rtl/ucu_field_dec.sv
module ucu_field_dec #(
  parameter int unsigned W     = 3,
  localparam int unsigned LINES = (1 << W) - 1
) (
  input  logic             en_i,
  input  logic [W-1:0]     code_i,
  output logic [LINES-1:0] dec_o
);

  // code 0 is the group's no-op
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign dec_o[i] = en_i && (code_i == W'(i + 1));
  end

endmodule

// File: rtl/ucu_sequencer.sv
module ucu_sequencer
  import ucu_pkg::*;
#(
  parameter int unsigned AW    = UADDR_W,
  parameter int unsigned OW    = OPC_W,
  parameter int unsigned SHIFT = MAP_SHIFT,
  localparam int unsigned GL   = (1 << GRP_W) - 1,
  localparam int unsigned ML   = (1 << MEM_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OW-1:0]     opcode_i,
  input  logic [FLAG_N-1:0] flags_i,
  output logic [GL-1:0]     src_o,
  output logic [GL-1:0]     dst_o,
  output logic [GL-1:0]     alu_o,
  output logic [ML-1:0]     mem_o,
  output logic [AW-1:0]     uaddr_o
);

  ph_e           phase_q;
  logic [AW-1:0] car_q;
  uword_t        cbr_q;
  uword_t        rom_word;
  logic [AW-1:0] nxt_addr;
  logic          exec_en;

  ucu_store #(.AW(AW)) u_store (
    .addr_i (car_q),
    .word_o (rom_word)
  );

  ucu_next_addr #(.AW(AW), .OW(OW), .SHIFT(SHIFT)) u_next (
    .car_i    (car_q),
    .na_i     (cbr_q.na),
    .fsel_i   (cbr_q.fsel),
    .target_i (cbr_q.target),
    .flags_i  (flags_i),
    .opcode_i (opcode_i),
    .nxt_o    (nxt_addr)
  );

  // fetch loads the buffer; execute drives controls and advances the address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FETCH;
      car_q   <= '0;
      cbr_q   <= '0;
    end else if (phase_q == PH_FETCH) begin
      cbr_q   <= rom_word;
      phase_q <= PH_EXEC;
    end else begin
      car_q   <= nxt_addr;
      phase_q <= PH_FETCH;
    end
  end

  assign exec_en = (phase_q == PH_EXEC);
  assign uaddr_o = car_q;

  ucu_field_dec #(.W(GRP_W)) u_dec_src (.en_i(exec_en), .code_i(cbr_q.src), .dec_o(src_o));
  ucu_field_dec #(.W(GRP_W)) u_dec_dst (.en_i(exec_en), .code_i(cbr_q.dst), .dec_o(dst_o));
  ucu_field_dec #(.W(GRP_W)) u_dec_alu (.en_i(exec_en), .code_i(cbr_q.alu), .dec_o(alu_o));
  ucu_field_dec #(.W(MEM_W)) u_dec_mem (.en_i(exec_en), .code_i(cbr_q.mem), .dec_o(mem_o));

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (uaddr_o == '0 && src_o == '0 && dst_o == '0 && alu_o == '0 && mem_o == '0));

  // R2
  a_r2_phase_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (phase_q != $past(phase_q)));

  a_r2_addr_held_in_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && phase_q == PH_EXEC) |-> $stable(car_q));

  a_r2_fetch_no_controls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FETCH) |-> (src_o == '0 && dst_o == '0 && alu_o == '0 && mem_o == '0));

  // R3
  a_r3_groups_onehot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_o) && $onehot0(dst_o) && $onehot0(alu_o) && $onehot0(mem_o));

  a_r3_zero_code_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXEC) |-> (((src_o != '0) == (cbr_q.src != '0)) &&
                               ((mem_o != '0) == (cbr_q.mem != '0))));

  // R4, R8
  a_r4_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXEC && cbr_q.na == NA_INC) |=> (car_q == $past(car_q) + AW'(1)));

  // R5
  a_r5_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXEC && cbr_q.na == NA_JMP) |=> (car_q == $past(cbr_q.target)));

  // R6
  a_r6_cond_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXEC && cbr_q.na == NA_JCC && flags_i[cbr_q.fsel])
      |=> (car_q == $past(cbr_q.target)));

  a_r6_cond_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXEC && cbr_q.na == NA_JCC && !flags_i[cbr_q.fsel])
      |=> (car_q == $past(car_q) + AW'(1)));

  // R7
  a_r7_dispatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXEC && cbr_q.na == NA_MAP)
      |=> (car_q == AW'({$past(opcode_i), {SHIFT{1'b0}}})));

endmodule

// File: tb/ucu_sequencer_tb.sv
module ucu_sequencer_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] opcode_i = 4'h0;
  logic [3:0] flags_i = 4'h0;
  logic [6:0] src_o, dst_o, alu_o;
  logic [2:0] mem_o;
  logic [5:0] uaddr_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  ucu_sequencer u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (opcode_i),
    .flags_i  (flags_i),
    .src_o    (src_o),
    .dst_o    (dst_o),
    .alu_o    (alu_o),
    .mem_o    (mem_o),
    .uaddr_o  (uaddr_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [6:0] oh7(int c);
    return (c == 0) ? 7'd0 : 7'(1 << (c - 1));
  endfunction

  function automatic logic [2:0] oh3(int c);
    return (c == 0) ? 3'd0 : 3'(1 << (c - 1));
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one microinstruction: execute clock, then fetch clock of the next
  task automatic step(int ea, int s, int d, int a, int m, string tag);
    @(posedge clk_i);
    @(negedge clk_i);
    chk({tag, " uaddr"}, int'(uaddr_o), ea);
    chk("R3 src", int'(src_o), int'(oh7(s)));
    chk("R3 dst", int'(dst_o), int'(oh7(d)));
    chk("R3 alu", int'(alu_o), int'(oh7(a)));
    chk("R3 mem", int'(mem_o), int'(oh3(m)));
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R2 fetch quiet", int'({src_o, dst_o, alu_o, mem_o}), 0);
  endtask

  // fetch routine; opcode is junk until just before the dispatch word (R7)
  task automatic fetch_dispatch(logic [3:0] opc);
    opcode_i = ~opc;
    step(0, 1, 1, 0, 1, "R9 fetch0");
    step(1, 2, 2, 1, 0, "R9 fetch1");
    opcode_i = opc;
    step(2, 0, 0, 0, 0, "R9 dispatch word");
    opcode_i = ~opc;
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 uaddr in reset", int'(uaddr_o), 0);
    chk("R1 controls in reset", int'({src_o, dst_o, alu_o, mem_o}), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_op1_zero_set;
    flags_i = 4'b0001;
    fetch_dispatch(4'd1);
    step(4, 3, 3, 2, 0, "R7 map op1");
    step(5, 0, 0, 3, 0, "R4 inc to 5");
    step(7, 0, 5, 0, 2, "R6 zero taken");
  endtask

  task automatic t_op1_zero_clear;
    flags_i = 4'b1110;  // only unselected flags set
    fetch_dispatch(4'd1);
    step(4, 3, 3, 2, 0, "R7 map op1");
    step(5, 0, 0, 3, 0, "R4 inc to 5");
    flags_i = 4'b1111;  // R5: unconditional jump ignores flags
    step(6, 4, 4, 0, 0, "R6 zero not taken");
    flags_i = 4'b0000;
  endtask

  task automatic t_op2;
    flags_i = 4'b0100;
    fetch_dispatch(4'd2);
    step(8, 0, 0, 4, 0, "R7 map op2");
    step(9, 5, 0, 0, 0, "R4 inc to 9");
    step(0, 1, 1, 0, 1, "R6 carry taken");
    step(1, 2, 2, 1, 0, "R9 fetch1");
    opcode_i = 4'd2;
    flags_i  = 4'b1011;
    step(2, 0, 0, 0, 0, "R9 dispatch word");
    step(8, 0, 0, 4, 0, "R7 map op2");
    step(9, 5, 0, 0, 0, "R4 inc to 9");
    step(10, 0, 6, 0, 0, "R6 carry clear");
  endtask

  task automatic t_op3;
    flags_i = 4'b0010;
    fetch_dispatch(4'd3);
    step(12, 0, 0, 6, 0, "R7 map op3");
    step(14, 0, 7, 0, 3, "R6 negative taken");
    flags_i = 4'b1000;
    fetch_dispatch(4'd3);
    step(12, 0, 0, 6, 0, "R7 map op3");
    step(13, 6, 0, 0, 0, "R6 negative clear");
    step(0, 1, 1, 0, 1, "R6 overflow taken");
    step(1, 2, 2, 1, 0, "R9 fetch1");
    opcode_i = 4'd3;
    flags_i  = 4'b0000;
    step(2, 0, 0, 0, 0, "R9 dispatch word");
    step(12, 0, 0, 6, 0, "R7 map op3");
    step(13, 6, 0, 0, 0, "R6 negative clear");
    step(14, 0, 7, 0, 3, "R6 overflow clear");
  endtask

  task automatic t_op15_wrap;
    flags_i = 4'b1111;
    fetch_dispatch(4'd15);
    for (int i = 60; i < 63; i++) step(i, 0, 0, 5, 0, "R4 top routine");
    step(63, 0, 0, 7, 0, "R8 last word");
    step(0, 1, 1, 0, 1, "R8 wrap to 0");
    step(1, 2, 2, 1, 0, "R9 fetch1");
    opcode_i = 4'd5;
    step(2, 0, 0, 0, 0, "R9 dispatch word");
    step(20, 0, 0, 0, 0, "R7 map unused op5");
    step(0, 1, 1, 0, 1, "R5 unused word jumps to 0");
    step(1, 2, 2, 1, 0, "R9 fetch1");
    opcode_i = 4'd0;
    step(2, 0, 0, 0, 0, "R9 dispatch word");
    step(0, 1, 1, 0, 1, "R7 map op0");
  endtask

  task automatic t_async_reset;
    flags_i = 4'b0000;
    step(1, 2, 2, 1, 0, "R9 fetch1");
    opcode_i = 4'd2;
    step(2, 0, 0, 0, 0, "R9 dispatch word");
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R2 exec of word 8 alu", int'(alu_o), int'(oh7(4)));
    rst_ni = 1'b0;
    #2;
    chk("R1 async uaddr", int'(uaddr_o), 0);
    chk("R1 async controls", int'({src_o, dst_o, alu_o, mem_o}), 0);
    @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(0, 1, 1, 0, 1, "R1 restart at 0");
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_op1_zero_set();
    t_op1_zero_clear();
    t_op2();
    t_op3();
    t_op15_wrap();
    t_async_reset();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

endmodule